// File: doc/BRIEF.md
# Unrolled Circular CORDIC Pipeline

This block is a feed-forward circular CORDIC engine with one register stage per micro-rotation. A new sample can enter on every clock. Each sample brings signed x, y and z words, a valid bit and a mode bit that picks rotation or vectoring. The valid and mode bits are registered next to the data at every stage, so a stream may switch modes from one cycle to the next and still produce one result per clock. There is no stall path: bubbles (valid low) move through the stages like ordinary samples, and their data words carry no meaning.

Stage i shifts x and y arithmetically right by the fixed amount i and adds or subtracts its own hardwired arctangent constant. In rotation mode the sign of z picks the direction, and the block returns gain-scaled cosine and sine in the final x and y. In vectoring mode the sign of y picks the direction, and the block returns the gain-scaled magnitude in x and the accumulated angle in z. Gain compensation and quadrant pre-rotation belong to the surrounding logic.

Angles use a binary-angle format: one z LSB equals pi / 2^(WIDTH-1), so the full signed range spans -pi to +pi. The stage constant is C_i = round(atan(2^-i) * 2^(WIDTH-1) / pi). The gain is K = product over i of sqrt(1 + 2^-2i), about 1.6468 at the default depth.

Top module: `cordic_pipe`

## Requirements
- R1: A sample presented with in_valid=1 appears with out_valid=1 exactly ITER clock cycles later. Samples leave in arrival order, one per cycle. A cycle with in_valid=0 produces no output sample (out_valid=0 in the matching output cycle).
- R2: While rst_n is low, every stage register is cleared, so out_valid, out_x, out_y and out_z all read 0.
- R3: For a rotation sample (in_vec=0) with |in_z| <= 2^(WIDTH-2) (+-90 degrees), out_x = K(x cos z - y sin z) and out_y = K(y cos z + x sin z), each within 4e-4 of K*sqrt(x^2+y^2) plus 64 LSB. out_z is within 2e-4 rad of zero.
- R4: For a vectoring sample (in_vec=1) with in_x > 0, out_x = K*sqrt(x^2+y^2) and out_y is near 0, both within the R3 bound. out_z = in_z + atan2(y, x) within 2e-4 rad. In every vectoring stage, x never decreases.
- R5: The mode bit is captured with its own sample. In a stream that alternates modes cycle by cycle, every sample gets the result of its own mode.
- R6: A vectoring sample with x = y = 0 gives out_x = out_y = 0 exactly and out_z = in_z + sum of C_i for i = 0 .. ITER-1 exactly (modulo 2^WIDTH). In every stage y = 0 selects the positive direction.
- R7: A rotation sample with x = y = 0 gives out_x = out_y = 0 exactly, whatever z is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all stages register on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all stage registers |
| in_valid | input | 1 | Marks the current input as a sample |
| in_vec | input | 1 | Mode of the sample: 0 rotation, 1 vectoring |
| in_x | input | WIDTH | Signed input x |
| in_y | input | WIDTH | Signed input y |
| in_z | input | WIDTH | Signed input angle, LSB = pi / 2^(WIDTH-1) |
| out_valid | output | 1 | Marks out_x/out_y/out_z as a result |
| out_x | output | WIDTH | Final x (cosine or magnitude, times K) |
| out_y | output | WIDTH | Final y (sine in rotation, residue in vectoring) |
| out_z | output | WIDTH | Final z (residual angle or atan2 plus in_z) |

## Verification
The per-stage assertions assume the datapath never wraps. So |in_x| and |in_y| must stay within 2^(WIDTH-4), so that the gain-grown vector still fits in WIDTH bits. Vectoring samples must also have a non-negative x, and rotation angles must lie within +-90 degrees. Every stimulus vector in the bench, table and directed alike, stays within these limits. The bubble cycles are the only exception: they carry out-of-range data with valid low, which the assertions do not look at because they are gated by the stage valid bit.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // Stage constant atan(2^-shift) in binary-angle LSBs (pi = 2^(width-1)).
    function automatic longint atan_lsb(int width, int shift);
        real t;
        real t2;
        real term;
        real acc;
        real scale;
        t = 1.0;
        for (int k = 0; k < shift; k++) begin
            t = t / 2.0;
        end
        if (shift == 0) begin
            acc = PI_R / 4.0;
        end else begin
            acc  = 0.0;
            term = t;
            t2   = t * t;
            for (int n = 0; n < 40; n++) begin
                if ((n % 2) == 0) acc = acc + term / real'(2 * n + 1);
                else              acc = acc - term / real'(2 * n + 1);
                term = term * t2;
            end
        end
        scale = 1.0;
        for (int k = 0; k < width - 1; k++) begin
            scale = scale * 2.0;
        end
        return longint'(acc * scale / PI_R);
    endfunction

endpackage

// File: rtl/cordic_microrot.sv
module cordic_microrot #(
    parameter int WIDTH = 32,
    parameter int SHIFT = 0,
    parameter logic signed [WIDTH-1:0] ATAN_C = '0
) (
    input  logic                    vec,
    input  logic signed [WIDTH-1:0] x,
    input  logic signed [WIDTH-1:0] y,
    input  logic signed [WIDTH-1:0] z,
    output logic signed [WIDTH-1:0] nx,
    output logic signed [WIDTH-1:0] ny,
    output logic signed [WIDTH-1:0] nz
);
    logic signed [WIDTH-1:0] xs;
    logic signed [WIDTH-1:0] ys;
    logic                    pos;

    always_comb begin
        xs = x >>> SHIFT;
        ys = y >>> SHIFT;
        // rotation steers on z, vectoring on y; zero counts as positive
        pos = vec ? ~y[WIDTH-1] : ~z[WIDTH-1];
        if (!vec) begin
            nx = pos ? (x - ys) : (x + ys);
            ny = pos ? (y + xs) : (y - xs);
            nz = pos ? (z - ATAN_C) : (z + ATAN_C);
        end else begin
            nx = pos ? (x + ys) : (x - ys);
            ny = pos ? (y - xs) : (y + xs);
            nz = pos ? (z + ATAN_C) : (z - ATAN_C);
        end
    end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
    parameter int WIDTH = 32,
    parameter int SHIFT = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic                    in_vec,
    input  logic signed [WIDTH-1:0] in_x,
    input  logic signed [WIDTH-1:0] in_y,
    input  logic signed [WIDTH-1:0] in_z,
    output logic                    out_vld,
    output logic                    out_vec,
    output logic signed [WIDTH-1:0] out_x,
    output logic signed [WIDTH-1:0] out_y,
    output logic signed [WIDTH-1:0] out_z
);
    localparam logic signed [WIDTH-1:0] ATAN_C =
        WIDTH'(cordic_pkg::atan_lsb(WIDTH, SHIFT));

    typedef struct packed {
        logic                    vld;
        logic                    vec;
        logic signed [WIDTH-1:0] x;
        logic signed [WIDTH-1:0] y;
        logic signed [WIDTH-1:0] z;
    } stg_t;

    stg_t stg_d;
    stg_t stg_q;

    logic signed [WIDTH-1:0] rot_x;
    logic signed [WIDTH-1:0] rot_y;
    logic signed [WIDTH-1:0] rot_z;

    cordic_microrot #(
        .WIDTH (WIDTH),
        .SHIFT (SHIFT),
        .ATAN_C(ATAN_C)
    ) u_microrot (
        .vec(in_vec),
        .x  (in_x),
        .y  (in_y),
        .z  (in_z),
        .nx (rot_x),
        .ny (rot_y),
        .nz (rot_z)
    );

    always_comb begin
        stg_d.vld = in_vld;
        stg_d.vec = in_vec;
        stg_d.x   = rot_x;
        stg_d.y   = rot_y;
        stg_d.z   = rot_z;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign out_vld = stg_q.vld;
    assign out_vec = stg_q.vec;
    assign out_x   = stg_q.x;
    assign out_y   = stg_q.y;
    assign out_z   = stg_q.z;

    // R6
    zero_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_vec && in_x == '0 && in_y == '0)
        |=> (out_x == '0 && out_y == '0 && out_z == $past(in_z) + ATAN_C));

    // R7
    zero_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_vec && in_x == '0 && in_y == '0)
        |=> (out_x == '0 && out_y == '0));

    // R4
    vec_x_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_vec && !in_x[WIDTH-1])
        |=> ($signed(out_x) >= $signed($past(in_x))));

    // R3
    rot_z_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_vec && !in_z[WIDTH-1])
        |=> ($signed(out_z) < $signed($past(in_z))));
endmodule

// File: rtl/cordic_pipe.sv
module cordic_pipe #(
    parameter int WIDTH = 32,
    parameter int ITER  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_vec,
    input  logic signed [WIDTH-1:0] in_x,
    input  logic signed [WIDTH-1:0] in_y,
    input  logic signed [WIDTH-1:0] in_z,
    output logic                    out_valid,
    output logic signed [WIDTH-1:0] out_x,
    output logic signed [WIDTH-1:0] out_y,
    output logic signed [WIDTH-1:0] out_z
);
    localparam int NODES = ITER + 1;

    logic                    vld_c [NODES];
    logic [ITER:0]           vec_c;
    logic signed [WIDTH-1:0] x_c   [NODES];
    logic signed [WIDTH-1:0] y_c   [NODES];
    logic signed [WIDTH-1:0] z_c   [NODES];
    logic                    unused_vec_tail;

    assign vld_c[0] = in_valid;
    assign vec_c[0] = in_vec;
    assign x_c[0]   = in_x;
    assign y_c[0]   = in_y;
    assign z_c[0]   = in_z;

    for (genvar g = 0; g < ITER; g++) begin : g_stage
        cordic_stage #(
            .WIDTH(WIDTH),
            .SHIFT(g)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vld (vld_c[g]),
            .in_vec (vec_c[g]),
            .in_x   (x_c[g]),
            .in_y   (y_c[g]),
            .in_z   (z_c[g]),
            .out_vld(vld_c[g+1]),
            .out_vec(vec_c[g+1]),
            .out_x  (x_c[g+1]),
            .out_y  (y_c[g+1]),
            .out_z  (z_c[g+1])
        );
    end

    assign unused_vec_tail = vec_c[ITER];
    assign out_valid = vld_c[ITER];
    assign out_x     = x_c[ITER];
    assign out_y     = y_c[ITER];
    assign out_z     = z_c[ITER];
endmodule

// File: tb/test_cordic_pipe.sv
`timescale 1ns/1ps
module test_cordic_pipe;
    localparam int  W    = 32;
    localparam int  ITER = 16;
    localparam int  NV   = 12;
    localparam real PI   = 3.14159265358979323846;

    typedef struct packed {
        logic vec;
        int   x;
        int   y;
        int   z;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{1'b0, 268435456,          0,   357913941},
        '{1'b0, 268435456,          0,  -536870912},
        '{1'b1, 268435456,  268435456,           0},
        '{1'b0, 100000000, -150000000,   715827883},
        '{1'b1, 268435456, -134217728,           0},
        '{1'b0, 200000000,   50000000,  1061804942},
        '{1'b1,       100,  200000000,     1000000},
        '{1'b0, -120000000,  90000000, -1061804942},
        '{1'b1, 150000000,          1,    -2000000},
        '{1'b0, 268435456,          0,           0},
        '{1'b1, 268435456,          0,           0},
        '{1'b0,         0,  268435456,  -357913941}
    };

    logic                 clk;
    logic                 rst_n;
    logic                 in_valid;
    logic                 in_vec;
    logic signed [W-1:0]  in_x;
    logic signed [W-1:0]  in_y;
    logic signed [W-1:0]  in_z;
    logic                 out_valid;
    logic signed [W-1:0]  out_x;
    logic signed [W-1:0]  out_y;
    logic signed [W-1:0]  out_z;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int cap_n = 0;
    int cap_cyc [64];
    int cap_x   [64];
    int cap_y   [64];
    int cap_z   [64];
    int in_cyc  [NV];

    cordic_pipe #(.WIDTH(W), .ITER(ITER)) i_cordic_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .in_x(in_x), .in_y(in_y), .in_z(in_z), .out_valid(out_valid),
        .out_x(out_x), .out_y(out_y), .out_z(out_z)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 64) begin
            cap_cyc[cap_n] = cyc;
            cap_x[cap_n]   = out_x;
            cap_y[cap_n]   = out_y;
            cap_z[cap_n]   = out_z;
            cap_n          = cap_n + 1;
        end
    end

    initial begin
        #(8 * 50000);
        n_bad = n_bad + 1;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_near(input string tag, input int act, input real exp, input real tol);
        real d;
        n_chk = n_chk + 1;
        d = real'(act) - exp;
        if (d < 0.0) d = -d;
        if (d > tol) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0.1f (tol %0.1f)", tag, act, exp, tol);
        end
    endtask

    task automatic drive(input logic v, input logic m, input int x, input int y, input int z);
        in_valid = v;
        in_vec   = m;
        in_x     = x;
        in_y     = y;
        in_z     = z;
    endtask

    task automatic send_one(input logic m, input int x, input int y, input int z, output int idx);
        @(negedge clk);
        idx = cap_n;
        drive(1'b1, m, x, y, z);
        @(negedge clk);
        drive(1'b0, 1'b0, 0, 0, 0);
        repeat (ITER + 2) @(negedge clk);
    endtask

    real gain;
    real ang_lsb;
    real zr;
    real mag;
    real txy;
    real tz;
    real ex;
    real ey;
    real ez;
    int  base;
    int  idle_hits;
    int  csum;
    int  idx;

    initial begin
        gain = 1.0;
        for (int i = 0; i < ITER; i++) gain = gain * $sqrt(1.0 + 2.0 ** (-2.0 * i));
        ang_lsb = PI / (2.0 ** (W - 1));
        tz = 2.0e-4 / ang_lsb;

        // reset with an active-looking input
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 77, -99, 1234);
        repeat (3) @(negedge clk);
        chk_eq("R2 out_valid in reset", out_valid, 0);
        chk_eq("R2 out_x in reset", out_x, 0);
        chk_eq("R2 out_z in reset", out_z, 0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, -5, 5, 9);
        idle_hits = 0;
        repeat (ITER + 2) begin
            @(negedge clk);
            if (out_valid) idle_hits = idle_hits + 1;
        end
        chk_eq("R1 bubbles give no output", idle_hits, 0);

        // table stream, modes alternating per cycle, one bubble inside (R5)
        base = cap_n;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(1'b1, TBL[k].vec, TBL[k].x, TBL[k].y, TBL[k].z);
            in_cyc[k] = cyc;
            if (k == 5) begin
                @(negedge clk);
                drive(1'b0, 1'b1, -2000000000, 2000000000, 5);
            end
        end
        @(negedge clk);
        drive(1'b0, 1'b0, 0, 0, 0);
        repeat (ITER + 3) @(negedge clk);
        chk_eq("R1 output sample count", cap_n - base, NV);

        for (int k = 0; k < NV; k++) begin
            chk_eq($sformatf("R1 latency vec%0d", k), cap_cyc[base + k] - in_cyc[k], ITER);
            zr  = real'(TBL[k].z) * ang_lsb;
            mag = $sqrt(real'(TBL[k].x) * real'(TBL[k].x) + real'(TBL[k].y) * real'(TBL[k].y));
            txy = 4.0e-4 * gain * mag + 64.0;
            if (!TBL[k].vec) begin
                ex = gain * (real'(TBL[k].x) * $cos(zr) - real'(TBL[k].y) * $sin(zr));
                ey = gain * (real'(TBL[k].y) * $cos(zr) + real'(TBL[k].x) * $sin(zr));
                chk_near($sformatf("R3 R5 rot vec%0d x", k), cap_x[base + k], ex, txy);
                chk_near($sformatf("R3 R5 rot vec%0d y", k), cap_y[base + k], ey, txy);
                chk_near($sformatf("R3 rot vec%0d z", k), cap_z[base + k], 0.0, tz);
            end else begin
                ez = real'(TBL[k].z) + $atan2(real'(TBL[k].y), real'(TBL[k].x)) / ang_lsb;
                chk_near($sformatf("R4 R5 vect vec%0d x", k), cap_x[base + k], gain * mag, txy);
                chk_near($sformatf("R4 vect vec%0d y", k), cap_y[base + k], 0.0, txy);
                chk_near($sformatf("R4 R5 vect vec%0d z", k), cap_z[base + k], ez, tz);
            end
        end

        // R6: zero vector in vectoring mode, exact
        csum = 0;
        for (int i = 0; i < ITER; i++)
            csum = csum + $rtoi($atan(2.0 ** (-1.0 * i)) / ang_lsb + 0.5);
        send_one(1'b1, 0, 0, 12345, idx);
        chk_eq("R6 zero vector count", cap_n - idx, 1);
        chk_eq("R6 zero vector x", cap_x[idx], 0);
        chk_eq("R6 zero vector y", cap_y[idx], 0);
        chk_eq("R6 zero vector z", cap_z[idx], 12345 + csum);

        // R7: zero vector in rotation mode, exact
        send_one(1'b0, 0, 0, 500000000, idx);
        chk_eq("R7 zero rotation count", cap_n - idx, 1);
        chk_eq("R7 zero rotation x", cap_x[idx], 0);
        chk_eq("R7 zero rotation y", cap_y[idx], 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule